// File: doc/BRIEF.md
# Odd-Even Merging Network

This block takes two runs of unsigned values and combines them into one sorted run. Each run holds N/2 values and must already be in nondecreasing order. The block puts all N values on its output in nondecreasing order. It is a fixed network of compare-exchange cells laid out in log2(N) columns. Each column has at most N/2 cells. The whole network uses 1 + (N/2)·(log2(N)-1) cells, which is 9 cells in 3 columns for N = 8.

The wiring follows the recursive odd-even scheme. The first column compares lane i with lane i+N/2. Each later column compares lanes that lie a stride k apart inside windows of width 2k, where k halves from one column to the next. The last column joins the neighbour pairs (1,2), (3,4) and so on up to (N-3,N-2).

A parameter places a register after every column. With the registers in place, a merge can enter on every clock and its result appears log2(N) cycles later. A valid flag travels through the pipeline beside the data. Without the registers the network is purely combinational.

Top module: `oem_merge_net`

## Requirements
- R1: Whenever `out_valid` is high, `out_data` holds exactly the N input values of the matching merge, with none lost or added, in nondecreasing order from lane 0 upward.
- R2: Lane i occupies bits [i*W +: W] of `in_data` and `out_data`. Lanes 0..N/2-1 carry the first sorted run and lanes N/2..N-1 carry the second. Output lane 0 holds the smallest value.
- R3: Each compare-exchange cell places the smaller of its two values on its lower-numbered lane and the larger on its higher-numbered lane.
- R4: Equal values give a correct result. Runs containing repeated keys, including all-equal inputs, merge into the correct multiset in nondecreasing order.
- R5: With PIPELINE=1, a merge presented with `in_valid` high appears on the outputs with `out_valid` high exactly log2(N) clock cycles later. `out_valid` stays low in the cycles that have no matching input.
- R6: A new merge can be presented on every clock cycle. Back-to-back inputs produce back-to-back results in the same order.
- R7: `rst` is synchronous and active high. It clears only the valid flags in the pipeline, so `out_valid` is low in the cycle after `rst` is sampled high and in every cycle until new valid input reaches the output. Merges that were in flight when reset arrived never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the column registers |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a merge to perform |
| in_data | input | N*W | Two sorted runs, lane i at bits [i*W +: W] |
| out_valid | output | 1 | Marks `out_data` as a finished merge |
| out_data | output | N*W | Merged values, lane 0 smallest |

## Verification
Several properties are checked on every cycle. Each cell's outputs must be an ordered permutation of its inputs. Each registered column must keep the sum of its lane values and must advance the valid flag by exactly one step. Reset must clear each column's flag, and the output must be sorted whenever it is marked valid. Other properties only the bench's scenarios can show: that the exact multiset comes out, that the latency from `in_valid` to `out_valid` is log2(N) cycles, that a flow of back-to-back merges keeps its order, and that a reset in mid-flow discards every merge in flight. The bench compares these against a behavioural two-pointer merge model on every clock. Its inputs include random runs, duplicate-heavy runs, disjoint runs in both orders, and extreme values.

// File: rtl/oem_pkg.sv
package oem_pkg;

  // Low lane of a compare-exchange cell in column s of an n-lane merge.
  // The partner lane is a + (n >> (s+1)).
  function automatic logic cmp_lo(input int n, input int s, input int a);
    int k;
    k = n >> (s + 1);
    if (s == 0) return (a < k);
    if (a < k || (a + k) >= n) return 1'b0;
    return ((a - k) % (2 * k)) < k;
  endfunction

  // High lane of a cell in column s (partner of a lower lane).
  function automatic logic cmp_hi(input int n, input int s, input int a);
    int k;
    k = n >> (s + 1);
    if (a < k) return 1'b0;
    return cmp_lo(n, s, a - k);
  endfunction

  // Number of cells in the whole network: 1 + (n/2)*(log2(n)-1).
  function automatic int cell_count(input int n);
    return 1 + (n / 2) * ($clog2(n) - 1);
  endfunction

endpackage

// File: rtl/oem_cmp_cell.sv
module oem_cmp_cell #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         swap_o
);

  assign swap_o = (a_i > b_i);
  assign lo_o   = swap_o ? b_i : a_i;
  assign hi_o   = swap_o ? a_i : b_i;

  // R3: outputs ordered and a permutation of inputs
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r3_cell_order: assert (lo_o <= hi_o &&
        ((lo_o == a_i && hi_o == b_i) || (lo_o == b_i && hi_o == a_i)))
        else $error("cell output not an ordered permutation");
    end
  end

endmodule

// File: rtl/oem_column.sv
module oem_column
  import oem_pkg::*;
#(
  parameter int N     = 8,
  parameter int W     = 8,
  parameter int STAGE = 0,
  parameter bit REG   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [N*W-1:0] d_i,
  output logic         v_o,
  output logic [N*W-1:0] d_o
);

  localparam int K  = N >> (STAGE + 1);
  localparam int SW = W + $clog2(N) + 1;

  logic [W-1:0] lane_in  [N];
  logic [W-1:0] lane_res [N];
  logic [N-1:0] swap_ev;
  logic [N*W-1:0] res_flat;

  genvar a;
  generate
    for (a = 0; a < N; a++) begin : g_lane
      assign lane_in[a] = d_i[a*W +: W];
      assign res_flat[a*W +: W] = lane_res[a];
      if (cmp_lo(N, STAGE, a)) begin : g_cell
        oem_cmp_cell #(.W(W)) u_cell (
          .a_i   (lane_in[a]),
          .b_i   (lane_in[a+K]),
          .lo_o  (lane_res[a]),
          .hi_o  (lane_res[a+K]),
          .swap_o(swap_ev[a])
        );
      end else if (cmp_hi(N, STAGE, a)) begin : g_hi
        assign swap_ev[a] = 1'b0;
      end else begin : g_pass
        assign lane_res[a] = lane_in[a];
        assign swap_ev[a]  = 1'b0;
      end
    end
  endgenerate

  function automatic logic [SW-1:0] lane_sum(input logic [N*W-1:0] v);
    logic [SW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + SW'(v[i*W +: W]);
    return s;
  endfunction

  generate
    if (REG) begin : g_reg
      logic           v_q;
      logic [N*W-1:0] d_q;
      logic [SW-1:0]  sum_in, sum_q;

      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_i;
      end

      always_ff @(posedge clk) begin
        d_q <= res_flat;
      end

      assign sum_in = lane_sum(d_i);
      assign sum_q  = lane_sum(d_q);
      assign v_o    = v_q;
      assign d_o    = d_q;

      // R5: valid advances exactly one column per clock
      a_r5_valid_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (v_q == $past(v_i)))
        else $error("valid flag did not advance by one step");

      // R1: a column neither loses nor adds value
      a_r1_sum_kept: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && v_q) |-> (sum_q == $past(sum_in)))
        else $error("column changed the lane sum");

      // R7: reset clears this column's valid flag
      a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> !v_q)
        else $error("valid not cleared by reset");
    end else begin : g_comb
      assign v_o = v_i;
      assign d_o = res_flat;
    end
  endgenerate

endmodule

// File: rtl/oem_merge_net.sv
module oem_merge_net
  import oem_pkg::*;
#(
  parameter int N        = 8,
  parameter int W        = 8,
  parameter bit PIPELINE = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data
);

  localparam int STAGES = $clog2(N);
  localparam int CELLS  = cell_count(N);

  logic           v_chain [STAGES+1];
  logic [N*W-1:0] d_chain [STAGES+1];

  assign v_chain[0] = in_valid;
  assign d_chain[0] = in_data;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_col
      oem_column #(.N(N), .W(W), .STAGE(s), .REG(PIPELINE)) u_col (
        .clk(clk),
        .rst(rst),
        .v_i(v_chain[s]),
        .d_i(d_chain[s]),
        .v_o(v_chain[s+1]),
        .d_o(d_chain[s+1])
      );
    end
  endgenerate

  assign out_valid = v_chain[STAGES];
  assign out_data  = d_chain[STAGES];

  function automatic logic is_nondecreasing(input logic [N*W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < N; i++)
      if (v[(i-1)*W +: W] > v[i*W +: W]) ok = 1'b0;
    return ok;
  endfunction

  logic out_sorted;
  assign out_sorted = is_nondecreasing(out_data);

  // R1: a valid output is always in nondecreasing order
  a_r1_sorted: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sorted)
    else $error("valid output not sorted (network of %0d cells)", CELLS);

endmodule

// File: tb/oem_merge_net_tb.sv
module oem_merge_net_tb;

  localparam int N = 8;
  localparam int W = 8;
  localparam int L = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic [N*W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  oem_merge_net #(.N(N), .W(W), .PIPELINE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // behavioural reference: two-pointer merge of the two halves
  function automatic logic [N*W-1:0] ref_merge(input logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    int ia, ib;
    ia = 0; ib = N / 2;
    for (int o = 0; o < N; o++) begin
      if (ib >= N || (ia < N / 2 && v[ia*W +: W] <= v[ib*W +: W])) begin
        r[o*W +: W] = v[ia*W +: W]; ia++;
      end else begin
        r[o*W +: W] = v[ib*W +: W]; ib++;
      end
    end
    return r;
  endfunction

  logic [L-1:0]   ev;
  logic [N*W-1:0] ed [L];

  always @(posedge clk) begin
    if (rst) ev <= '0;
    else     ev <= {ev[L-2:0], in_valid};
    ed[0] <= ref_merge(in_data);
    for (int i = 1; i < L; i++) ed[i] <= ed[i-1];
  end

  task automatic check(input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      check((cur_req == "R7") ? "R7" : "R5", {{(N*W-1){1'b0}}, out_valid},
            {{(N*W-1){1'b0}}, ev[L-1]});
      if (ev[L-1]) check(cur_req, out_data, ed[L-1]);
    end
  end

  // build two sorted halves; mode picks the value pattern
  function automatic logic [N*W-1:0] make_input(input int mode);
    int vals [N];
    int t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (mode)
        1: vals[i] = $urandom_range(0, 3);
        2: vals[i] = (i < N/2) ? $urandom_range(0, 100) : $urandom_range(101, 255);
        3: vals[i] = (i < N/2) ? $urandom_range(150, 255) : $urandom_range(0, 149);
        4: vals[i] = 77;
        5: vals[i] = ($urandom_range(0, 1) == 1) ? 255 : 0;
        default: vals[i] = $urandom_range(0, 255);
      endcase
    end
    for (int h = 0; h < 2; h++)
      for (int i = h*N/2; i < (h+1)*N/2; i++)
        for (int j = i + 1; j < (h+1)*N/2; j++)
          if (vals[j] < vals[i]) begin t = vals[i]; vals[i] = vals[j]; vals[j] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(vals[i]);
    return r;
  endfunction

  task automatic drive(input logic v, input logic [N*W-1:0] d);
    in_valid = v;
    in_data  = d;
    @(negedge clk);
  endtask

  int lat;
  int seen;

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", {{(N*W-1){1'b0}}, out_valid}, '0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R5: single merge, measure latency; R2: fixed lane layout
    in_valid = 1'b1;
    in_data  = {8'd70, 8'd50, 8'd30, 8'd10, 8'd60, 8'd40, 8'd20, 8'd0};
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    check("R5", N*W'(lat), N*W'(L));
    check("R2", out_data, {8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10, 8'd0});
    repeat (4) drive(1'b0, '0);

    // R1 / R3: random runs, back to back
    cur_req = "R1";
    for (int i = 0; i < 40; i++) drive(1'b1, make_input(0));
    cur_req = "R3";
    for (int i = 0; i < 10; i++) drive(1'b1, make_input(2));
    for (int i = 0; i < 10; i++) drive(1'b1, make_input(3));
    drive(1'b0, '0);
    // R4: duplicates and all-equal
    cur_req = "R4";
    for (int i = 0; i < 20; i++) drive(1'b1, make_input(1));
    for (int i = 0; i < 3; i++)  drive(1'b1, make_input(4));
    for (int i = 0; i < 10; i++) drive(1'b1, make_input(5));
    repeat (L + 1) drive(1'b0, '0);

    // R6: burst of 12 with gaps around it, count results
    cur_req = "R6";
    seen = 0;
    fork
      begin
        for (int i = 0; i < 12; i++) drive(1'b1, make_input(0));
        repeat (L + 2) drive(1'b0, '0);
      end
      begin
        repeat (12 + L + 2) begin
          if (out_valid) seen++;
          @(negedge clk);
        end
      end
    join
    check("R6", N*W'(seen), N*W'(12));

    // R7: reset mid-flow discards in-flight merges
    cur_req = "R7";
    for (int i = 0; i < 5; i++) drive(1'b1, make_input(0));
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7", {{(N*W-1){1'b0}}, out_valid}, '0);
    seen = 0;
    repeat (L + 2) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    check("R7", N*W'(seen), '0);
    for (int i = 0; i < 6; i++) drive(1'b1, make_input(1));
    repeat (L + 2) drive(1'b0, '0);

    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule